// File: doc/BRIEF.md
# Circuit-Switched Mesh Router

This block is one node of a two-dimensional mesh network in which traffic is circuit switched. It has five ports: local, north, east, south and west. Each port has a request, a grant and a data lane in each direction, and every wire is unidirectional. A source opens a circuit by raising its request with the destination coordinates on its data lane. The router maps those coordinates to an output port with fixed dimension-ordered routing. A round-robin arbiter on that output settles any contention. The router then passes the request and the address on to the next hop.

When the far end answers with a grant, the grant is returned to the source over the same reserved connection. From then on, data words flow through the crossbar. The source closes the circuit by dropping its request. That frees the output and clears the request towards the next hop, so the teardown ripples down the path. A request that loses arbitration is not dropped. It waits at its input and retries until it wins or until its source withdraws it.

The router's own coordinates are set by parameters. Several such nodes, wired port to port, form the mesh.

Top module: `cs_mesh_router`

## Requirements
- R1: While reset is high, and in the cycle after it, all of `req_out`, `grant_out` and `data_out` are zero.
- R2: Port numbers are local=0, north=1, east=2, south=3, west=4. The destination is x = data bits [X_W-1:0] and y = data bits [X_W+Y_W-1:X_W]. The router picks east if x > MY_X and west if x < MY_X. Otherwise it picks north if y > MY_Y, south if y < MY_Y, and local if both coordinates match.
- R3: With an output free, `req_out` of the selected port rises two clock cycles after the source raises `req_in` with the address. `data_out` of that port carries the address in the same cycle. `req_out` stays low one cycle after the request.
- R4: `grant_out` of the source rises one cycle after `grant_in` of its reserved output is seen high. It never rises before that.
- R5: Once the grant is given, `data_out` of the reserved output equals the source's `data_in` of the previous cycle.
- R6: One cycle after the source drops `req_in`, `req_out`, `grant_out` and `data_out` of the circuit are all zero.
- R7: An output that is reserved stays with its holder while another input requests it. The waiting input receives no grant. When the holder releases, `req_out` is low for one cycle and then rises for the waiting input, carrying that input's address.
- R8: Among inputs that request a free output in the same cycle, the winner is the first one found after the previous winner of that output, going up through the port numbers and wrapping around. After reset the search starts at port 0.
- R9: An input that withdraws its request before winning arbitration produces no `req_out`, even after the output becomes free.
- R10: Circuits that use different outputs are set up and carry data at the same time without interfering.
- R11: A `grant_in` on an output that is not reserved for a waiting input has no effect on that input's `grant_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 5 | Circuit request from each neighbour (one bit per port) |
| data_in | input | 5*DATA_W | Address, then payload, from each neighbour; port p uses bits [p*DATA_W +: DATA_W] |
| grant_out | output | 5 | Grant returned towards each requesting neighbour |
| req_out | output | 5 | Request forwarded on each output port |
| grant_in | input | 5 | Grant returned by each downstream neighbour |
| data_out | output | 5*DATA_W | Forwarded address or payload per output port |

## Verification
The hardest situation to reach is a hand-over on a contended output. One input must hold the output while a second input waits in arbitration. The holder then releases, and the bench has to see the one-cycle gap and then the waiting input's own address on the output. The stimulus raises two requests for the router's own coordinates in the same cycle. It drops the winner and watches the output cycle by cycle. A later run first gives the output to a middle port, so that round-robin rotation picks the higher-numbered of two new requesters over the lower one. A third sequence withdraws a waiting request before the holder lets go. The output must then stay silent.

// File: rtl/cs_router_pkg.sv
package cs_router_pkg;

  localparam int NPORTS = 5;
  localparam int PW     = $clog2(NPORTS);

  // Port numbering is visible at the pins: bit p of every vector is port p.
  typedef enum logic [PW-1:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_EAST  = 3'd2,
    P_SOUTH = 3'd3,
    P_WEST  = 3'd4
  } port_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQUEST,
    S_WAIT_GRANT,
    S_ACTIVE,
    S_RELEASE
  } ctrl_state_e;

endpackage

// File: rtl/cs_route_decode.sv
module cs_route_decode
  import cs_router_pkg::*;
#(
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  output port_e          out_port
);

  localparam logic [X_W-1:0] HERE_X = X_W'(MY_X);
  localparam logic [Y_W-1:0] HERE_Y = Y_W'(MY_Y);

  // X first, then Y: no turn from the Y axis back to X, so no cycles.
  always_comb begin
    if (dst_x > HERE_X)      out_port = P_EAST;
    else if (dst_x < HERE_X) out_port = P_WEST;
    else if (dst_y > HERE_Y) out_port = P_NORTH;
    else if (dst_y < HERE_Y) out_port = P_SOUTH;
    else                     out_port = P_LOCAL;
  end

endmodule

// File: rtl/cs_input_ctrl.sv
module cs_input_ctrl
  import cs_router_pkg::*;
#(
  parameter int X_W  = 2,
  parameter int Y_W  = 2,
  parameter int MY_X = 0,
  parameter int MY_Y = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_in,
  input  logic [X_W+Y_W-1:0] addr,
  input  logic [NPORTS-1:0]  grant_in_vec,
  input  logic               win,
  output port_e              sel_port,
  output logic               want,
  output logic               drop,
  output logic               grant_out
);

  ctrl_state_e st, st_nxt;
  port_e       port_q, port_dec;
  logic        grant_q;

  cs_route_decode #(
    .X_W (X_W),
    .Y_W (Y_W),
    .MY_X(MY_X),
    .MY_Y(MY_Y)
  ) u_dec (
    .dst_x   (addr[X_W-1:0]),
    .dst_y   (addr[X_W+Y_W-1:X_W]),
    .out_port(port_dec)
  );

  assign want     = (st == S_REQUEST) && req_in;
  assign sel_port = port_q;

  always_comb begin
    st_nxt = st;
    drop   = 1'b0;
    unique case (st)
      S_IDLE:       if (req_in) st_nxt = S_REQUEST;
      S_REQUEST: begin
        if (!req_in)  st_nxt = S_IDLE;
        else if (win) st_nxt = S_WAIT_GRANT;
      end
      S_WAIT_GRANT: begin
        if (!req_in) begin
          st_nxt = S_RELEASE;
          drop   = 1'b1;
        end else if (grant_in_vec[port_q]) begin
          st_nxt = S_ACTIVE;
        end
      end
      S_ACTIVE: begin
        if (!req_in) begin
          st_nxt = S_RELEASE;
          drop   = 1'b1;
        end
      end
      S_RELEASE:    st_nxt = S_IDLE;
      default:      st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      port_q  <= P_LOCAL;
      grant_q <= 1'b0;
    end else begin
      st      <= st_nxt;
      grant_q <= (st_nxt == S_ACTIVE);
      if (st == S_IDLE && req_in) port_q <= port_dec;
    end
  end

  assign grant_out = grant_q;

endmodule

// File: rtl/cs_rr_arbiter.sv
module cs_rr_arbiter #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  want,
  input  logic [N-1:0]  drop,
  output logic [N-1:0]  win,
  output logic          own_vld_nxt,
  output logic [IW-1:0] own_idx_nxt
);

  logic          own_vld;
  logic [IW-1:0] own_idx;
  logic [IW-1:0] last;
  logic [IW-1:0] pick;
  logic [IW-1:0] cand;
  logic          found;
  logic          grant_now;

  // Search starts just after the previous winner and wraps around.
  always_comb begin
    found = 1'b0;
    pick  = last;
    cand  = last;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last) + k) % N);
      if (!found && want[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  // Release and a new award never share a cycle.
  assign grant_now = !own_vld && found;

  always_comb begin
    win = '0;
    if (grant_now) win[pick] = 1'b1;
  end

  assign own_vld_nxt = own_vld ? !drop[own_idx] : found;
  assign own_idx_nxt = grant_now ? pick : own_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld <= 1'b0;
      own_idx <= '0;
      last    <= IW'(N-1);
    end else begin
      own_vld <= own_vld_nxt;
      own_idx <= own_idx_nxt;
      if (grant_now) last <= pick;
    end
  end

endmodule

// File: rtl/cs_crossbar.sv
module cs_crossbar
  import cs_router_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din     [NPORTS],
  input  logic              vld_nxt [NPORTS],
  input  logic [PW-1:0]     idx_nxt [NPORTS],
  output logic              req_q   [NPORTS],
  output logic [DATA_W-1:0] dout_q  [NPORTS]
);

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[o]  <= 1'b0;
        dout_q[o] <= '0;
      end else begin
        req_q[o]  <= vld_nxt[o];
        dout_q[o] <= vld_nxt[o] ? din[idx_nxt[o]] : '0;
      end
    end
  end

endmodule

// File: rtl/cs_mesh_router.sv
module cs_mesh_router
  import cs_router_pkg::*;
#(
  parameter int X_W    = 2,
  parameter int Y_W    = 2,
  parameter int DATA_W = 16,
  parameter int MY_X   = 0,
  parameter int MY_Y   = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        req_in,
  input  logic [NPORTS*DATA_W-1:0] data_in,
  output logic [NPORTS-1:0]        grant_out,
  output logic [NPORTS-1:0]        req_out,
  input  logic [NPORTS-1:0]        grant_in,
  output logic [NPORTS*DATA_W-1:0] data_out
);

  localparam int AW = X_W + Y_W;

  logic [DATA_W-1:0] din_a   [NPORTS];
  logic [DATA_W-1:0] dout_a  [NPORTS];
  logic              reqo_a  [NPORTS];
  port_e             sel     [NPORTS];
  logic [NPORTS-1:0] want;
  logic [NPORTS-1:0] drop;
  logic [NPORTS-1:0] want_m  [NPORTS];
  logic [NPORTS-1:0] win_m   [NPORTS];
  logic              vld_nxt [NPORTS];
  logic [PW-1:0]     idx_nxt [NPORTS];

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    assign din_a[i] = data_in[i*DATA_W +: DATA_W];

    cs_input_ctrl #(
      .X_W (X_W),
      .Y_W (Y_W),
      .MY_X(MY_X),
      .MY_Y(MY_Y)
    ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .req_in      (req_in[i]),
      .addr        (din_a[i][AW-1:0]),
      .grant_in_vec(grant_in),
      .win         (win_m[sel[i]][i]),
      .sel_port    (sel[i]),
      .want        (want[i]),
      .drop        (drop[i]),
      .grant_out   (grant_out[i])
    );
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_arb
    always_comb begin
      for (int i = 0; i < NPORTS; i++) begin
        want_m[o][i] = want[i] && (sel[i] == port_e'(o));
      end
    end

    cs_rr_arbiter #(
      .N (NPORTS),
      .IW(PW)
    ) u_arb (
      .clk        (clk),
      .rst        (rst),
      .want       (want_m[o]),
      .drop       (drop),
      .win        (win_m[o]),
      .own_vld_nxt(vld_nxt[o]),
      .own_idx_nxt(idx_nxt[o])
    );

    assign req_out[o]                   = reqo_a[o];
    assign data_out[o*DATA_W +: DATA_W] = dout_a[o];
  end

  cs_crossbar #(
    .DATA_W(DATA_W)
  ) u_xbar (
    .clk    (clk),
    .rst    (rst),
    .din    (din_a),
    .vld_nxt(vld_nxt),
    .idx_nxt(idx_nxt),
    .req_q  (reqo_a),
    .dout_q (dout_a)
  );

endmodule

// File: rtl/cs_mesh_router_chk.sv
module cs_mesh_router_chk
  import cs_router_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPORTS-1:0]        req_in,
  input logic [NPORTS-1:0]        grant_in,
  input logic [NPORTS-1:0]        req_out,
  input logic [NPORTS-1:0]        grant_out,
  input logic [NPORTS*DATA_W-1:0] data_out
);

  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (req_out == '0 && grant_out == '0 && data_out == '0));

  // R10: every forwarded request is backed by a distinct live source
  a_r10_req_out_bounded: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ($countones(req_out) <= $countones($past(req_in))));

  for (genvar p = 0; p < NPORTS; p++) begin : g_p
    // R6
    a_r6_release_drops_grant: assert property (@(posedge clk) disable iff (rst)
      !req_in[p] |=> !grant_out[p]);

    // R4
    a_r4_grant_from_downstream: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $rose(grant_out[p])) |-> ($past(req_in[p]) && $past(|grant_in)));

    // R3
    a_r3_setup_has_source: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $rose(req_out[p])) |-> $past(|req_in));
  end

endmodule

bind cs_mesh_router cs_mesh_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_in   (req_in),
  .grant_in (grant_in),
  .req_out  (req_out),
  .grant_out(grant_out),
  .data_out (data_out)
);

// File: tb/test_cs_mesh_router.sv
`timescale 1ns/1ps
module test_cs_mesh_router;

  localparam int NP = 5;
  localparam int DW = 8;
  localparam int MX = 1;
  localparam int MY = 2;

  typedef struct packed {
    logic [2:0] src;
    logic [1:0] dx;
    logic [1:0] dy;
    logic [2:0] exp_port;
  } route_vec_t;

  // Ports: 0 local, 1 north, 2 east, 3 south, 4 west; this node sits at (1,2)
  localparam route_vec_t RT [8] = '{
    '{3'd0, 2'd3, 2'd0, 3'd2},
    '{3'd1, 2'd0, 2'd3, 3'd4},
    '{3'd2, 2'd1, 2'd3, 3'd1},
    '{3'd3, 2'd1, 2'd0, 3'd3},
    '{3'd4, 2'd1, 2'd2, 3'd0},
    '{3'd0, 2'd2, 2'd2, 3'd2},
    '{3'd3, 2'd0, 2'd2, 3'd4},
    '{3'd1, 2'd1, 2'd1, 3'd3}
  };

  localparam logic [DW-1:0] HOME = 8'h09; // x=1, y=2

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NP-1:0]      req_in = '0;
  logic [NP*DW-1:0]   data_in = '0;
  logic [NP-1:0]      grant_in = '0;
  logic [NP-1:0]      grant_out;
  logic [NP-1:0]      req_out;
  logic [NP*DW-1:0]   data_out;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cs_mesh_router #(
    .X_W(2), .Y_W(2), .DATA_W(DW), .MY_X(MX), .MY_Y(MY)
  ) i_cs_mesh_router (
    .clk(clk), .rst(rst), .req_in(req_in), .data_in(data_in),
    .grant_out(grant_out), .req_out(req_out), .grant_in(grant_in),
    .data_out(data_out)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dout(input int o);
    return data_out[o*DW +: DW];
  endfunction

  task automatic put(input int p, input logic [DW-1:0] v);
    data_in[p*DW +: DW] = v;
  endtask

  task automatic do_reset();
    req_in = '0; grant_in = '0; data_in = '0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic run_route(input int s, input logic [DW-1:0] addr, input int o,
                           input logic [DW-1:0] pay);
    req_in[s] = 1'b1; put(s, addr);
    step(1);
    chk("R3 no req_out after one cycle", 64'(req_out), 64'(0));
    step(1);
    chk("R2 routed output", 64'(req_out), 64'(1) << o);
    chk("R3 address forwarded", 64'(dout(o)), 64'(addr));
    chk("R4 no grant before downstream", 64'(grant_out), 64'(0));
    grant_in[o] = 1'b1;
    step(1);
    chk("R4 grant returned", 64'(grant_out), 64'(1) << s);
    put(s, pay);
    step(1);
    chk("R5 payload forwarded", 64'(dout(o)), 64'(pay));
    req_in[s] = 1'b0;
    step(1);
    chk("R6 req_out cleared", 64'(req_out), 64'(0));
    chk("R6 grant_out cleared", 64'(grant_out), 64'(0));
    chk("R6 data_out cleared", 64'(data_out), 64'(0));
    grant_in = '0; put(s, '0);
    step(1);
  endtask

  initial begin
    do_reset();
    chk("R1 reset req_out", 64'(req_out), 64'(0));
    chk("R1 reset grant_out", 64'(grant_out), 64'(0));
    chk("R1 reset data_out", 64'(data_out), 64'(0));

    for (int n = 0; n < 8; n++) begin
      run_route(int'(RT[n].src), {4'h0, RT[n].dy, RT[n].dx},
                int'(RT[n].exp_port), 8'hA0 + 8'(n));
    end

    // R10: two circuits on different outputs at once
    req_in[0] = 1'b1; put(0, 8'h03);   // x=3 -> east
    req_in[3] = 1'b1; put(3, 8'h08);   // x=0 -> west
    step(2);
    chk("R10 both outputs requested", 64'(req_out), 64'h14);
    chk("R10 east address", 64'(dout(2)), 64'h03);
    chk("R10 west address", 64'(dout(4)), 64'h08);
    grant_in = 5'b10100;
    step(1);
    chk("R10 both grants", 64'(grant_out), 64'h09);
    put(0, 8'h3C); put(3, 8'hC3);
    step(1);
    chk("R10 east payload", 64'(dout(2)), 64'h3C);
    chk("R10 west payload", 64'(dout(4)), 64'hC3);
    req_in = '0;
    step(1);
    chk("R6 both released", 64'(req_out), 64'(0));
    grant_in = '0; data_in = '0;
    step(1);

    // R11 then R9: east input waits on local output
    req_in[2] = 1'b1; put(2, HOME);
    step(2);
    chk("R3 local requested", 64'(req_out), 64'h01);
    grant_in = 5'b11110;
    step(1);
    chk("R11 foreign grants ignored", 64'(grant_out), 64'(0));
    grant_in = '0;
    req_in[1] = 1'b1; put(1, HOME);
    step(2);
    chk("R7 holder keeps output", 64'(req_out), 64'h01);
    chk("R7 holder address kept", 64'(dout(0)), 64'(HOME));
    grant_in[0] = 1'b1;
    step(1);
    chk("R7 only holder granted", 64'(grant_out), 64'h04);
    req_in[1] = 1'b0;
    step(1);
    req_in[2] = 1'b0;
    step(1);
    chk("R6 holder released", 64'(req_out), 64'(0));
    grant_in = '0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R9 withdrawn request stays silent", 64'(req_out), 64'(0));
    end
    data_in = '0;

    // R7 / R8: simultaneous contention after reset
    do_reset();
    req_in[1] = 1'b1; put(1, HOME);
    req_in[4] = 1'b1; put(4, HOME);
    step(2);
    chk("R7 local requested once", 64'(req_out), 64'h01);
    grant_in[0] = 1'b1;
    step(1);
    chk("R8 port 1 wins after reset", 64'(grant_out), 64'h02);
    put(1, 8'h5A);
    step(1);
    chk("R5 winner payload", 64'(dout(0)), 64'h5A);
    req_in[1] = 1'b0;
    step(1);
    chk("R7 gap on hand-over", 64'(req_out), 64'(0));
    chk("R7 no grant in gap", 64'(grant_out), 64'(0));
    grant_in = '0;
    step(1);
    chk("R7 waiting input takes over", 64'(req_out), 64'h01);
    chk("R7 waiting address forwarded", 64'(dout(0)), 64'(HOME));
    grant_in[0] = 1'b1;
    step(1);
    chk("R7 waiting input granted", 64'(grant_out), 64'h10);
    req_in = '0;
    step(1);
    grant_in = '0; data_in = '0;
    step(1);

    // R8 rotation: port 2 wins alone, then 1 and 4 compete -> 4
    req_in[2] = 1'b1; put(2, HOME);
    step(2);
    grant_in[0] = 1'b1;
    step(1);
    chk("R4 single local grant", 64'(grant_out), 64'h04);
    req_in[2] = 1'b0;
    step(1);
    grant_in = '0;
    step(1);
    req_in[1] = 1'b1; put(1, HOME);
    req_in[4] = 1'b1; put(4, HOME);
    step(2);
    grant_in[0] = 1'b1;
    step(1);
    chk("R8 rotation picks port 4", 64'(grant_out), 64'h10);

    // R1: reset in the middle of a live circuit
    rst = 1'b1;
    step(1);
    chk("R1 mid-run reset req_out", 64'(req_out), 64'(0));
    chk("R1 mid-run reset grant_out", 64'(grant_out), 64'(0));
    chk("R1 mid-run reset data_out", 64'(data_out), 64'(0));
    req_in = '0; grant_in = '0; data_in = '0;
    step(1);
    rst = 1'b0;
    step(1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule